// File: doc/BRIEF.md
# Lockable Two-Way Instruction Cache

A read-only, two-way set-associative instruction cache. Each line holds 32 bytes, which is eight 32-bit instructions stored as four 64-bit words. A fetch sends the virtual set index and the 64-bit word select. In the same cycle it sends the physical tag from translation. The tag compare therefore uses the translated address while the arrays are read with untranslated bits. A hit returns one 64-bit word, which is two instructions. The lower 32 bits hold the instruction at the lower address.

On a miss the cache stalls the fetch side. It requests the line from memory and takes four 64-bit beats, writing each beat into the data array as it arrives. It then presents the requested word. One parity bit per tag and one parity bit per 32-bit instruction are written on fill and checked on every lookup. A parity mismatch is treated as a miss, and the line is fetched again.

Replacement uses one least-recently-used bit per set. A lock input freezes way A: while it is high, every refill goes into way B, so code already in way A stays resident. An invalidate-all input clears every valid bit, including those of locked lines.

Top module: `icache_lockable`

## Requirements
- R1: After reset, fetch_ready is 1, rdata_valid is 0, mem_req is 0 and no line is valid.
- R2: A fetch accepted on a rising edge that hits (valid, matching tag, good parity) drives rdata_valid high in the following cycle. rdata then holds word fetch_vidx[1:0] of that line. The fetch side stays ready and no memory request is made.
- R3: A fetch accepted on a rising edge that misses drives mem_req high and fetch_ready low in the following cycle, with mem_line_addr = {fetch_ptag, fetch_vidx[IDX_W+1:2]}.
- R4: Refill beats are stored in arrival order as words 0 to 3 of the line. On the edge that accepts the fourth beat, mem_req falls, fetch_ready rises, and rdata_valid rises with the requested word.
- R5: When unlocked, a miss replaces the way that was not used most recently in its set. After reset, way A counts as the victim.
- R6: While lock_a is 1, a miss never replaces way A. The refill goes into way B, and the lines in way A keep hitting.
- R7: A line whose stored tag parity or word parity does not match its contents causes a miss and is fetched again. par_inject=1 during a fill beat stores inverted parity for that line.
- R8: A one-cycle inv_all pulse invalidates every line in both ways, including lines kept by the lock, so the next fetch to any of them misses.
- R9: mem_req stays high and mem_line_addr stays stable from the miss until the fourth beat is accepted. Fetches are not accepted during this time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_valid | input | 1 | Fetch request |
| fetch_vidx | input | IDX_W+2 | Virtual set index (upper bits) and 64-bit word select (low 2 bits) |
| fetch_ptag | input | TAG_W | Physical tag of the fetch |
| fetch_ready | output | 1 | Cache can accept a fetch |
| rdata_valid | output | 1 | rdata holds a returned fetch word |
| rdata | output | 64 | Two instructions, lower address in bits 31:0 |
| lock_a | input | 1 | Freeze way A; all refills go to way B |
| inv_all | input | 1 | Invalidate every line |
| mem_req | output | 1 | Line refill request, held until the fourth beat |
| mem_line_addr | output | TAG_W+IDX_W | Physical line address {tag, index} |
| mem_beat_valid | input | 1 | Refill beat valid |
| mem_beat_data | input | 64 | Refill beat data |
| par_inject | input | 1 | Store inverted parity for the beat being filled |

## Verification
A hit returns its word one cycle after the accepting edge. A miss shows mem_req and a low fetch_ready one cycle after that edge. The refilled word appears on the edge that accepts the fourth beat. The driver makes each fetch request at a falling edge and checks the hit or miss result at the next falling edge, which is after exactly one rising edge. The memory model checks the held request on each beat and checks the returned word at the falling edge that follows the final beat. A scoreboard queue pairs each returned word with the word the driver predicted, so returns out of order or missing are caught as well.

// File: rtl/icache_lockable.sv
module icache_lockable #(
  parameter int SETS  = 16,
  parameter int TAG_W = 24,
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   fetch_valid,
  input  logic [IDX_W+1:0]       fetch_vidx,
  input  logic [TAG_W-1:0]       fetch_ptag,
  output logic                   fetch_ready,
  output logic                   rdata_valid,
  output logic [63:0]            rdata,
  input  logic                   lock_a,
  input  logic                   inv_all,
  output logic                   mem_req,
  output logic [TAG_W+IDX_W-1:0] mem_line_addr,
  input  logic                   mem_beat_valid,
  input  logic [63:0]            mem_beat_data,
  input  logic                   par_inject
);

  logic [TAG_W-1:0] tag_q  [2][SETS];
  logic             tpar_q [2][SETS];
  logic [63:0]      dat_q  [2][SETS][4];
  logic [1:0]       dpar_q [2][SETS][4];
  logic [SETS-1:0]  vld_q  [2];
  logic [SETS-1:0]  lru_q;

  logic             filling_q, f_way_q;
  logic [IDX_W-1:0] f_idx_q;
  logic [TAG_W-1:0] f_tag_q;
  logic [1:0]       f_word_q, beat_q;

  logic [IDX_W-1:0] idx;
  logic [1:0]       wsel;
  logic [1:0]       way_ok;
  logic [63:0]      wd [2];
  logic             hit, accept, last, victim;

  assign idx  = fetch_vidx[IDX_W+1:2];
  assign wsel = fetch_vidx[1:0];

  for (genvar w = 0; w < 2; w++) begin : g_way
    assign wd[w]     = dat_q[w][idx][wsel];
    assign way_ok[w] = vld_q[w][idx] && (tag_q[w][idx] == fetch_ptag)
                       && ((^tag_q[w][idx]) == tpar_q[w][idx])
                       && ({^wd[w][63:32], ^wd[w][31:0]} == dpar_q[w][idx][wsel]);
  end

  assign hit           = |way_ok;
  assign accept        = fetch_valid && !filling_q;
  assign last          = filling_q && mem_beat_valid && (beat_q == 2'd3);
  assign victim        = lock_a ? 1'b1 : lru_q[idx];
  assign fetch_ready   = !filling_q;
  assign mem_req       = filling_q;
  assign mem_line_addr = {f_tag_q, f_idx_q};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      filling_q   <= 1'b0;
      beat_q      <= 2'd0;
      f_way_q     <= 1'b0;
      f_idx_q     <= '0;
      f_tag_q     <= '0;
      f_word_q    <= 2'd0;
      lru_q       <= '0;
      vld_q[0]    <= '0;
      vld_q[1]    <= '0;
      rdata_valid <= 1'b0;
      rdata       <= '0;
    end else begin
      rdata_valid <= 1'b0;
      if (inv_all) begin
        vld_q[0] <= '0;
        vld_q[1] <= '0;
      end
      if (accept && hit) begin
        rdata_valid <= 1'b1;
        rdata       <= way_ok[1] ? wd[1] : wd[0];
        lru_q[idx]  <= ~way_ok[1];
      end
      if (accept && !hit) begin
        filling_q          <= 1'b1;
        beat_q             <= 2'd0;
        f_way_q            <= victim;
        f_idx_q            <= idx;
        f_tag_q            <= fetch_ptag;
        f_word_q           <= wsel;
        vld_q[victim][idx] <= 1'b0;
      end
      if (filling_q && mem_beat_valid) begin
        beat_q <= beat_q + 2'd1;
        if (beat_q == 2'd3) begin
          filling_q               <= 1'b0;
          rdata_valid             <= 1'b1;
          rdata                   <= (f_word_q == 2'd3) ? mem_beat_data
                                                        : dat_q[f_way_q][f_idx_q][f_word_q];
          lru_q[f_idx_q]          <= ~f_way_q;
          vld_q[f_way_q][f_idx_q] <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (filling_q && mem_beat_valid) begin
      dat_q[f_way_q][f_idx_q][beat_q]  <= mem_beat_data;
      dpar_q[f_way_q][f_idx_q][beat_q] <= {^mem_beat_data[63:32], ^mem_beat_data[31:0]}
                                          ^ {2{par_inject}};
      if (beat_q == 2'd3) begin
        tag_q[f_way_q][f_idx_q]  <= f_tag_q;
        tpar_q[f_way_q][f_idx_q] <= (^f_tag_q) ^ par_inject;
      end
    end
  end

  AST_HIT_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    accept && hit |=> rdata_valid && fetch_ready && !mem_req); // R2
  AST_MISS_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !hit |=> mem_req && !fetch_ready); // R3
  AST_FILL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    last |=> rdata_valid && fetch_ready && !mem_req); // R4
  AST_LOCK_SPARES_A: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !hit && lock_a |=> f_way_q); // R6
  AST_INV_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    inv_all && !last |=> (vld_q[0] == '0) && (vld_q[1] == '0)); // R8
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !last |=> mem_req && $stable(mem_line_addr)); // R9

endmodule

// File: tb/tb_icache_lockable.sv
module tb_icache_lockable;
  localparam int SETS = 16, TAG_W = 24, IDX_W = 4, LA_W = TAG_W + IDX_W;

  logic clk = 0, rst_n = 0;
  logic fetch_valid = 0, lock_a = 0, inv_all = 0, mem_beat_valid = 0, par_inject = 0;
  logic [IDX_W+1:0] fetch_vidx = '0;
  logic [TAG_W-1:0] fetch_ptag = '0;
  logic [63:0] mem_beat_data = '0, rdata;
  logic fetch_ready, rdata_valid, mem_req;
  logic [LA_W-1:0] mem_line_addr;

  int total = 0, bad = 0;
  logic inj_mode = 0;
  logic [63:0] exp_q[$];

  always #4 clk = ~clk;

  icache_lockable #(.SETS(SETS), .TAG_W(TAG_W)) dut (.*);

  function automatic logic [63:0] gen(logic [LA_W-1:0] la, logic [1:0] b);
    return {4'hC, la, 6'd0, b, 24'h5A5A5A};
  endfunction

  task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic fetch(input logic [IDX_W-1:0] idx, input logic [1:0] w,
                       input logic [TAG_W-1:0] t, input logic miss, input string req);
    while (!fetch_ready) @(negedge clk);
    fetch_valid = 1; fetch_vidx = {idx, w}; fetch_ptag = t;
    exp_q.push_back(gen({t, idx}, w));
    @(negedge clk);
    fetch_valid = 0;
    if (miss)
      chk(mem_req && !fetch_ready && mem_line_addr == {t, idx}, {req, " miss/R3"},
          {34'd0, mem_req, fetch_ready, mem_line_addr}, {34'd0, 2'b10, t, idx});
    else
      chk(!mem_req && fetch_ready && rdata_valid, {req, " hit/R2"},
          {61'd0, mem_req, fetch_ready, rdata_valid}, 64'd3);
    while (!fetch_ready) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      if (rdata_valid) begin
        if (exp_q.size() == 0) chk(1'b0, "R2 unexpected return", rdata, 64'd0);
        else begin
          logic [63:0] e;
          e = exp_q.pop_front();
          chk(rdata == e, "R2/R4 returned word", rdata, e);
        end
      end
    end
  end

  initial begin : memory
    forever begin
      @(negedge clk);
      if (mem_req) begin
        logic [LA_W-1:0] la;
        la = mem_line_addr;
        repeat (2) @(negedge clk);
        for (int b = 0; b < 4; b++) begin
          chk(mem_req && mem_line_addr == la, "R9 request held", {35'd0, mem_req, mem_line_addr},
              {35'd0, 1'b1, la});
          mem_beat_valid = 1; mem_beat_data = gen(la, 2'(b)); par_inject = inj_mode;
          @(negedge clk);
        end
        mem_beat_valid = 0; par_inject = 0;
        chk(rdata_valid && fetch_ready && !mem_req, "R4 word after final beat",
            {61'd0, rdata_valid, fetch_ready, mem_req}, 64'd6);
      end
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog", 64'd0, 64'd1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(fetch_ready && !rdata_valid && !mem_req, "R1 reset state",
        {61'd0, fetch_ready, rdata_valid, mem_req}, 64'd4);
    fetch(4'd1, 2'd2, 24'h000111, 1, "R1 empty after reset");
    fetch(4'd1, 2'd0, 24'h000111, 0, "R2 word0");
    fetch(4'd1, 2'd3, 24'h000111, 0, "R2 word3");
    fetch(4'd1, 2'd3, 24'h000222, 1, "R4 word3 bypass");
    // R5: LRU replacement in set 2
    fetch(4'd2, 2'd0, 24'h00A001, 1, "R5 fill A");
    fetch(4'd2, 2'd1, 24'h00A002, 1, "R5 fill B");
    fetch(4'd2, 2'd2, 24'h00A001, 0, "R5 touch A");
    fetch(4'd2, 2'd0, 24'h00A003, 1, "R5 replace B");
    fetch(4'd2, 2'd3, 24'h00A001, 0, "R5 A kept");
    fetch(4'd2, 2'd1, 24'h00A002, 1, "R5 B evicted");
    // R6: lock way A
    fetch(4'd3, 2'd0, 24'h00B001, 1, "R6 fill A unlocked");
    lock_a = 1;
    fetch(4'd3, 2'd1, 24'h00B002, 1, "R6 locked fill B");
    fetch(4'd3, 2'd2, 24'h00B003, 1, "R6 locked fill B again");
    fetch(4'd3, 2'd0, 24'h00B001, 0, "R6 A resident");
    fetch(4'd3, 2'd1, 24'h00B002, 1, "R6 B replaced");
    fetch(4'd3, 2'd3, 24'h00B001, 0, "R6 A still resident");
    fetch(4'd4, 2'd0, 24'h00C005, 1, "R6 empty set to B");
    fetch(4'd4, 2'd0, 24'h00C006, 1, "R6 empty set B replaced");
    fetch(4'd4, 2'd2, 24'h00C005, 1, "R6 A never filled");
    // R8: invalidate all, including locked lines
    inv_all = 1;
    @(negedge clk);
    inv_all = 0;
    fetch(4'd3, 2'd0, 24'h00B001, 1, "R8 locked line invalidated");
    fetch(4'd2, 2'd3, 24'h00A001, 1, "R8 line invalidated");
    lock_a = 0;
    // R7: parity error forces refill
    inj_mode = 1;
    fetch(4'd5, 2'd2, 24'h00D007, 1, "R7 fill with bad parity");
    inj_mode = 0;
    fetch(4'd5, 2'd2, 24'h00D007, 1, "R7 parity error refetch");
    fetch(4'd5, 2'd1, 24'h00D007, 0, "R7 good after refill");
    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R2 all returns seen", 64'(exp_q.size()), 64'd0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule